// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Unit

This block watches a bank of 24 general-purpose pins and keeps, for each pin, a sticky record of whether it changed and in which direction. Raw pin levels pass through a two-stage synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. Pin direction and the rising and falling enables come in as plain input vectors from registers held elsewhere.

Two status words can be read over a small register bus: an interrupt word and an edge word. For a pin with at least one enable on, the edge word holds the polarity of the edge that first raised its interrupt bit. For a pin with both enables off, the edge word is a sticky any-change flag and the interrupt bit stays clear. A nonzero write to either word clears every bit of both words. A registered OR of the interrupt word drives a single interrupt line.

The block has no state machine. All sequencing comes from the synchronizer depth and from the per-pin sticky bits.

Top module: `gpio_evt_status`

## Requirements
- R1: After reset both status words read zero and `irq` is low.
- R2: A pin with `dir_in` = 1 (input) sets its interrupt bit on a rising change when its `rise_en` bit is 1, or on a falling change when its `fall_en` bit is 1. A change in the direction that is not enabled leaves the interrupt bit clear.
- R3: A pin with `dir_in` = 0 never sets its interrupt bit or its edge bit, whatever its enables and changes.
- R4: When an enabled pin sets its interrupt bit, its edge bit takes the polarity of that edge (1 for rising, 0 for falling). The edge bit keeps that value while the interrupt bit stays set, even if later edges arrive.
- R5: For an input pin with both enables at 0, any change sets its edge bit to 1. The edge bit stays at 1 across later changes, and the interrupt bit stays clear.
- R6: A bus write to offset 0x0 or 0x4 with nonzero data clears all bits of both words on that clock edge. A write of zero data, or a write to any other offset, changes nothing.
- R7: If an edge would set a bit in the same cycle as a clear, the clear wins and the bit ends up 0.
- R8: Reading offset 0x0 returns the interrupt word in bits 23:0. Reading offset 0x4 returns the edge word in bits 23:0. Bits 31:24 are always 0, and every other offset reads 0.
- R9: `irq` is high in the cycle after any interrupt bit is set and low in the cycle after the word becomes zero.
- R10: A pin change presented before a clock edge appears in the status words after the third rising clock edge, and in `irq` after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 24 | Asynchronous pin levels |
| dir_in | input | 24 | Per-pin direction, 1 = input |
| rise_en | input | 24 | Per-pin rising-edge interrupt enable |
| fall_en | input | 24 | Per-pin falling-edge interrupt enable |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Registered OR of the interrupt word |

## Verification
Edge detection is driven with single rising and single falling changes under each enable, which separates a correct polarity match from an any-edge match. Changes in the direction that is not enabled, and changes on output-direction pins, show whether the enable and direction qualifiers actually gate the status bits. A rise followed by a fall is applied both to a doubly enabled pin and to a fully disabled pin, which distinguishes "first cause kept" from "last edge recorded", and distinguishes the polarity role of the edge bit from its sticky role. The bus is tried with a clear at each offset, with zero data, with an unmapped offset, and with a clear placed exactly on the cycle an edge lands, which exposes clear priority, the data check and the address decode.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
    localparam int PINS  = 24;
    localparam int BUS_W = 32;
    localparam int ADR_W = 4;
    localparam logic [ADR_W-1:0] OFS_INT  = 4'h0;
    localparam logic [ADR_W-1:0] OFS_EDGE = 4'h4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_INT  = 2'd1,
        SEL_EDGE = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
    parameter int W      = 24,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= pin_raw;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    // compare the settled level with its value one cycle earlier
    assign rise_o =  stage_q[STAGES-1] & ~prev_q;
    assign fall_o = ~stage_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/gpio_evt_cell.sv
module gpio_evt_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic is_input,
    input  logic en_rise,
    input  logic en_fall,
    input  logic rise,
    input  logic fall,
    input  logic clear,
    output logic int_o,
    output logic edge_o
);
    logic hit;
    logic watch;

    assign hit   = is_input & ((rise & en_rise) | (fall & en_fall));
    assign watch = is_input & ~en_rise & ~en_fall & (rise | fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_o  <= 1'b0;
            edge_o <= 1'b0;
        end else if (clear) begin
            int_o  <= 1'b0;
            edge_o <= 1'b0;
        end else if (hit) begin
            int_o <= 1'b1;
            if (!int_o) edge_o <= rise;  // first cause is kept
        end else if (watch) begin
            edge_o <= 1'b1;
        end
    end
endmodule

// File: rtl/gpio_evt_regif.sv
module gpio_evt_regif
    import gpio_evt_pkg::*;
#(
    parameter int W  = PINS,
    parameter int BW = BUS_W,
    parameter int AW = ADR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [BW-1:0] wdata,
    input  logic [W-1:0]  int_v,
    input  logic [W-1:0]  edge_v,
    output logic [BW-1:0] rdata,
    output logic          clear
);
    localparam int PAD = BW - W;

    reg_sel_e sel;

    always_comb begin
        if (addr == OFS_INT)       sel = SEL_INT;
        else if (addr == OFS_EDGE) sel = SEL_EDGE;
        else                       sel = SEL_NONE;
    end

    always_comb begin
        unique case (sel)
            SEL_INT:  rdata = {{PAD{1'b0}}, int_v};
            SEL_EDGE: rdata = {{PAD{1'b0}}, edge_v};
            default:  rdata = '0;
        endcase
    end

    assign clear = we && (sel != SEL_NONE) && (|wdata);
endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
    import gpio_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PINS-1:0]  pin_raw,
    input  logic [PINS-1:0]  dir_in,
    input  logic [PINS-1:0]  rise_en,
    input  logic [PINS-1:0]  fall_en,
    input  logic [ADR_W-1:0] bus_addr,
    input  logic             bus_we,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);
    logic [PINS-1:0] rise_v;
    logic [PINS-1:0] fall_v;
    logic [PINS-1:0] int_vec;
    logic [PINS-1:0] edge_vec;
    logic            clr;

    gpio_evt_sync #(.W(PINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_raw),
        .rise_o  (rise_v),
        .fall_o  (fall_v)
    );

    gpio_evt_regif #(.W(PINS), .BW(BUS_W), .AW(ADR_W)) u_regif (
        .addr   (bus_addr),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .int_v  (int_vec),
        .edge_v (edge_vec),
        .rdata  (bus_rdata),
        .clear  (clr)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_evt_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .is_input (dir_in[i]),
            .en_rise  (rise_en[i]),
            .en_fall  (fall_en[i]),
            .rise     (rise_v[i]),
            .fall     (fall_v[i]),
            .clear    (clr),
            .int_o    (int_vec[i]),
            .edge_o   (edge_vec[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |int_vec;
    end
endmodule

// File: rtl/gpio_evt_status_chk.sv
module gpio_evt_status_chk
    import gpio_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PINS-1:0]  dir_in,
    input logic [PINS-1:0]  rise_en,
    input logic [PINS-1:0]  fall_en,
    input logic [ADR_W-1:0] bus_addr,
    input logic             bus_we,
    input logic [BUS_W-1:0] bus_wdata,
    input logic [BUS_W-1:0] bus_rdata,
    input logic             irq,
    input logic [PINS-1:0]  int_q,
    input logic [PINS-1:0]  edge_q
);
    logic clr_seen;
    assign clr_seen = bus_we && (bus_wdata != '0) &&
                      (bus_addr == OFS_INT || bus_addr == OFS_EDGE);

    assert_out_pin_int_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_q & ~$past(int_q) & ~$past(dir_in)) == '0));

    assert_out_pin_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_q & ~$past(edge_q) & ~$past(dir_in)) == '0));

    assert_disabled_no_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_q & ~$past(int_q) & ~($past(rise_en) | $past(fall_en))) == '0));

    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_seen |=> (int_q == '0 && edge_q == '0));

    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:PINS] == '0);

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_q != '0) |=> irq);

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_q == '0) |=> !irq);
endmodule

bind gpio_evt_status gpio_evt_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_in    (dir_in),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .int_q     (int_vec),
    .edge_q    (edge_vec)
);

// File: tb/gpio_evt_status_tb.sv
`timescale 1ns/1ps
module gpio_evt_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pin_raw = '0;
    logic [23:0] dir_in = '0;
    logic [23:0] rise_en = '0;
    logic [23:0] fall_en = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    gpio_evt_status u_dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .dir_in(dir_in),
        .rise_en(rise_en), .fall_en(fall_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    // apply pin levels and wait long enough for status to settle
    task automatic pins(logic [23:0] v);
        @(negedge clk);
        pin_raw = v;
        repeat (4) @(negedge clk);
    endtask

    // move pins with every pin set as output, then clear, so nothing is left over
    task automatic prep(logic [23:0] v, logic [23:0] d, logic [23:0] re, logic [23:0] fe);
        dir_in = '0;
        pins(v);
        dir_in = d; rise_en = re; fall_en = fe;
        wr(4'h0, 32'h1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h0, d); chk("R1 int after reset", d, 32'h0);
        rd(4'h4, d); chk("R1 edge after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_rise_latency;
        logic [31:0] d;
        prep(24'h0, 24'hFFFFFF, 24'h000001, 24'h0);
        @(negedge clk); pin_raw = 24'h000001; bus_addr = 4'h0;
        repeat (2) @(negedge clk);
        chk("R10 int not yet set after two edges", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R10 R2 int set after third edge", bus_rdata, 32'h1);
        chk("R10 irq still low", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R9 irq high after int", {31'b0, irq}, 32'h1);
        rd(4'h4, d); chk("R4 rising polarity", d, 32'h1);
    endtask

    task automatic t_clear_edge_offset;
        logic [31:0] d;
        wr(4'h4, 32'h8000_0000);
        rd(4'h0, d); chk("R6 int cleared via edge offset", d, 32'h0);
        rd(4'h4, d); chk("R6 edge cleared", d, 32'h0);
        @(negedge clk);
        chk("R9 irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_fall;
        logic [31:0] d;
        prep(24'h000002, 24'hFFFFFF, 24'h0, 24'h000002);
        pins(24'h0);
        rd(4'h0, d); chk("R2 falling enabled sets int", d, 32'h2);
        rd(4'h4, d); chk("R4 falling polarity is 0", d, 32'h0);
    endtask

    task automatic t_wrong_dir;
        logic [31:0] d;
        prep(24'h000004, 24'hFFFFFF, 24'h000004, 24'h0);
        pins(24'h0);
        rd(4'h0, d); chk("R2 falling with only rise enabled", d, 32'h0);
        rd(4'h4, d); chk("R2 edge untouched on unenabled direction", d, 32'h0);
    endtask

    task automatic t_output_pin;
        logic [31:0] d;
        prep(24'h0, 24'hFFFFF7, 24'h000008, 24'h000018);
        pins(24'h000008);
        rd(4'h0, d); chk("R3 output pin no int", d, 32'h0);
        pins(24'h0);
        rd(4'h4, d); chk("R3 output pin no edge", d, 32'h0);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        prep(24'h0, 24'hFFFFFF, 24'h0, 24'h0);
        pins(24'h000010);
        rd(4'h4, d); chk("R5 any-edge flag on rise", d, 32'h10);
        rd(4'h0, d); chk("R5 no int for disabled pin", d, 32'h0);
        pins(24'h0);
        rd(4'h4, d); chk("R5 flag sticky after fall", d, 32'h10);
        chk("R5 irq stays low", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_first_cause;
        logic [31:0] d;
        prep(24'h0, 24'hFFFFFF, 24'h000020, 24'h000020);
        pins(24'h000020);
        pins(24'h0);
        rd(4'h0, d); chk("R2 both enables int set", d, 32'h20);
        rd(4'h4, d); chk("R4 first cause kept", d, 32'h20);
    endtask

    task automatic t_no_clear;
        logic [31:0] d;
        prep(24'h0, 24'hFFFFFF, 24'h0003C0, 24'h0);
        pins(24'h0003C0);
        wr(4'h0, 32'h0);
        rd(4'h0, d); chk("R6 zero data does not clear", d, 32'h3C0);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h4, d); chk("R6 other offset does not clear", d, 32'h3C0);
        rd(4'h8, d); chk("R8 unmapped offset reads 0", d, 32'h0);
        rd(4'hC, d); chk("R8 unmapped offset C reads 0", d, 32'h0);
        wr(4'h0, 32'h0000_0100);
        rd(4'h4, d); chk("R6 clear via int offset", d, 32'h0);
    endtask

    task automatic t_priority;
        logic [31:0] d;
        prep(24'h0, 24'hFFFFFF, 24'h800000, 24'h0);
        @(negedge clk); pin_raw = 24'h800000;
        repeat (2) @(negedge clk);
        bus_addr = 4'h4; bus_wdata = 32'h1; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rd(4'h0, d); chk("R7 clear beats same-cycle edge int", d, 32'h0);
        rd(4'h4, d); chk("R7 clear beats same-cycle edge edge", d, 32'h0);
    endtask

    task automatic t_wide;
        logic [31:0] d;
        prep(24'h0, 24'hFFFFFF, 24'hFFFFFF, 24'h0);
        pins(24'hFFFFFF);
        rd(4'h0, d); chk("R8 full word, reserved bits zero", d, 32'h00FF_FFFF);
        wr(4'h0, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rise_latency();
        t_clear_edge_offset();
        t_fall();
        t_wrong_dir();
        t_output_pin();
        t_disabled();
        t_first_cause();
        t_no_clear();
        t_priority();
        t_wide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule